// File: doc/BRIEF.md
# Mode-Gated Interrupt Aggregator

This block gathers interrupt conditions from three source groups (transmit, receive and system) and folds them into a single interrupt pin. Each source has one enable bit and one status bit. Status always reports the condition, whatever the enable says, so a host can poll the status words instead of watching the pin. Event sources latch into sticky status bits that clear when the status word is read. Level sources, such as buffer fill indications, report their live input.

An operating-mode input masks groups automatically. In transmit mode the receive group cannot raise the pin. In receive mode the transmit group cannot. In idle, only the system group can. The stored enable words are never modified by a mode change. A configuration word selects the pin polarity and selects push-pull or open-drain drive. In open-drain mode the output enable is high only while the interrupt is asserted.

Top module: `irqagg_top`

## Requirements
- R1: The interrupt is asserted exactly one clock edge after any gated, enabled status bit of any of the three groups is 1, and deasserts one edge after none is.
- R2: A source whose enable bit is 0 never raises the interrupt. Enable words are at address 0 (transmit), 1 (receive) and 2 (system); bit i enables source i.
- R3: With mode 2'b01 (transmit) the receive group is masked. With mode 2'b10 (receive) the transmit group is masked.
- R4: With mode 2'b00 (idle), or the unused code 2'b11, only the system group can raise the interrupt.
- R5: Changing the mode leaves the enable words unchanged; they read back as last written.
- R6: Status words are at addresses 4 (transmit), 5 (receive) and 6 (system) and are readable whether or not a source is enabled. Level-type bits report the live input: bits 1:0 of the transmit and receive groups, and bit 3 of the system group. All other bits are sticky and are set by a one-cycle event pulse.
- R7: A read strobe to a status address clears that word's sticky bits at the next edge. An event arriving in the same cycle stays set. Level bits are not cleared, and reads at other addresses clear nothing.
- R8: Configuration bit 0 (address 3) selects an active-low pin when 1 and an active-high pin when 0.
- R9: Configuration bit 1 selects open-drain drive when 1. In that mode the pad data holds the asserted level and the output enable follows the interrupt. In push-pull mode the output enable is always 1.
- R10: After reset the enables, configuration and sticky status are 0, the pad data is 0 and the output enable is 1. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ev | input | GW | Transmit group conditions (pulses or levels) |
| rx_ev | input | GW | Receive group conditions |
| sys_ev | input | GW | System group conditions |
| mode_i | input | 2 | Operating mode: 00 idle, 01 transmit, 10 receive, 11 treated as idle |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears sticky status on status addresses) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Combinational read data for reg_addr |
| irq_pad_o | output | 1 | Interrupt pad data |
| irq_pad_oe | output | 1 | Interrupt pad output enable |

## Verification
The assertions assume that reset is asserted from time zero and that the mode, event and register inputs change only away from the active edge. They also assume that the read and write strobes are never raised together. The bench drives every input on the falling edge and never combines a read with a write. It holds level-type conditions steady for the whole of a table row, and it pulses event-type sources for exactly one cycle. Under these assumptions, an enable word can change only through a write, and a sticky bit can drop only through a status read.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  typedef enum logic [1:0] {
    MD_IDLE = 2'b00,
    MD_TX   = 2'b01,
    MD_RX   = 2'b10,
    MD_RSVD = 2'b11
  } mode_e;

  localparam int unsigned NGRP = 3;
  localparam logic [2:0] ADDR_CFG = 3'd3;
  localparam logic [2:0] ADDR_ST0 = 3'd4;

  // group gate: bit0 transmit, bit1 receive, bit2 system
  function automatic logic [2:0] group_gate(input logic [1:0] m);
    logic [2:0] g;
    g = 3'b100;
    if (mode_e'(m) == MD_TX) g[0] = 1'b1;
    if (mode_e'(m) == MD_RX) g[1] = 1'b1;
    return g;
  endfunction

  // returns {pad data, pad output enable}
  function automatic logic [1:0] pad_drive(input logic act, input logic actlow,
                                           input logic od);
    logic lvl_on;
    lvl_on = ~actlow;
    if (od) return {lvl_on, act};
    return {act ? lvl_on : actlow, 1'b1};
  endfunction

endpackage

// File: rtl/irqagg_group.sv
module irqagg_group #(
  parameter int unsigned GW = 4,
  parameter logic [GW-1:0] LVL_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] ev_i,
  input  logic [GW-1:0] en_i,
  input  logic          gate_i,
  input  logic          clr_i,
  output logic [GW-1:0] status_o,
  output logic          req_o
);
  localparam logic [GW-1:0] STICKY_MASK = ~LVL_MASK;

  logic [GW-1:0] sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= (clr_i ? '0 : sticky_q) | (ev_i & STICKY_MASK);
  end

  assign status_o = (sticky_q & STICKY_MASK) | (ev_i & LVL_MASK);
  assign req_o    = gate_i & (|(status_o & en_i));
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int unsigned GW = 4,
  parameter int unsigned DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               addr,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [DW-1:0]            wdata,
  input  logic [NGRP-1:0][GW-1:0]  status_i,
  output logic [NGRP-1:0][GW-1:0]  en_o,
  output logic                     actlow_o,
  output logic                     od_o,
  output logic [NGRP-1:0]          clr_o,
  output logic [DW-1:0]            rdata
);
  logic [1:0] cfg_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         en_o[g] <= '0;
      else if (wr && addr == 3'(g))       en_o[g] <= wdata[GW-1:0];
    end
    assign clr_o[g] = rd && (addr == ADDR_ST0 + 3'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cfg_q <= '0;
    else if (wr && addr == ADDR_CFG) cfg_q <= wdata[1:0];
  end

  assign actlow_o = cfg_q[0];
  assign od_o     = cfg_q[1];

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0, 3'd1, 3'd2: rdata[GW-1:0] = en_o[addr[1:0]];
      3'd3:             rdata[1:0]    = cfg_q;
      3'd4, 3'd5, 3'd6: rdata[GW-1:0] = status_i[addr[1:0] - 2'd0 + 2'd0 == 2'd0 ? 0 :
                                                 (addr == 3'd5 ? 1 : 2)];
      default:          rdata = '0;
    endcase
    if (addr == 3'd4) rdata[GW-1:0] = status_i[0];
  end
endmodule

// File: rtl/irqagg_pad.sv
module irqagg_pad
  import irqagg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic actlow_i,
  input  logic od_i,
  output logic act_o,
  output logic pad_o,
  output logic pad_oe
);
  logic [1:0] drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_o <= 1'b0;
    else        act_o <= req_i;
  end

  assign drv    = pad_drive(act_o, actlow_i, od_i);
  assign pad_o  = drv[1];
  assign pad_oe = drv[0];
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned GW = 4,
  parameter int unsigned DW = 8,
  parameter logic [GW-1:0] TX_LVL  = 4'b0011,
  parameter logic [GW-1:0] RX_LVL  = 4'b0011,
  parameter logic [GW-1:0] SYS_LVL = 4'b1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] tx_ev,
  input  logic [GW-1:0] rx_ev,
  input  logic [GW-1:0] sys_ev,
  input  logic [1:0]    mode_i,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_pad_o,
  output logic          irq_pad_oe
);
  localparam logic [NGRP-1:0][GW-1:0] LVL_ALL = {SYS_LVL, RX_LVL, TX_LVL};

  logic [NGRP-1:0][GW-1:0] ev_w;
  logic [NGRP-1:0][GW-1:0] en_w;
  logic [NGRP-1:0][GW-1:0] status_w;
  logic [NGRP-1:0]         clr_w;
  logic [NGRP-1:0]         req_w;
  logic [NGRP-1:0]         gate_w;
  logic                    cfg_actlow;
  logic                    cfg_od;
  logic                    irq_act;

  assign ev_w   = {sys_ev, rx_ev, tx_ev};
  assign gate_w = group_gate(mode_i);

  irqagg_regs #(.GW(GW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .status_i(status_w), .en_o(en_w),
    .actlow_o(cfg_actlow), .od_o(cfg_od), .clr_o(clr_w), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    irqagg_group #(.GW(GW), .LVL_MASK(LVL_ALL[g])) u_grp (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_w[g]), .en_i(en_w[g]),
      .gate_i(gate_w[g]), .clr_i(clr_w[g]),
      .status_o(status_w[g]), .req_o(req_w[g])
    );
  end

  irqagg_pad u_pad (
    .clk(clk), .rst_n(rst_n), .req_i(|req_w), .actlow_i(cfg_actlow),
    .od_i(cfg_od), .act_o(irq_act), .pad_o(irq_pad_o), .pad_oe(irq_pad_oe)
  );
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int unsigned GW = 4,
  parameter logic [GW-1:0] SYS_LVL = 4'b1000
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          mode_i,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [2:0]          reg_addr,
  input logic [2:0][GW-1:0]  en_w,
  input logic [2:0][GW-1:0]  status_w,
  input logic [2:0]          req_w,
  input logic                irq_act,
  input logic                cfg_actlow,
  input logic                cfg_od,
  input logic                irq_pad_o,
  input logic                irq_pad_oe
);
  localparam logic [GW-1:0] SYS_STICKY = ~SYS_LVL;

  // R1: pin state follows the request of the previous cycle
  a_r1_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_w) |=> irq_act);

  // R4: idle allows only the system group
  a_r4_idle_sys_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'b00 || mode_i == 2'b11) && !req_w[2]) |=> !irq_act);

  // R3: in transmit mode a receive condition alone cannot raise the pin
  a_r3_tx_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && !req_w[0] && !req_w[2]) |=> !irq_act);

  // R5: enables change only through writes
  a_r5_enables_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en_w));

  // R7: sticky system bits persist until their status word is read
  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == 3'd6) |=>
      ((status_w[2] & $past(status_w[2]) & SYS_STICKY) == ($past(status_w[2]) & SYS_STICKY)));

  // R9: push-pull always drives
  a_r9_pushpull_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_od |-> irq_pad_oe);

  // R9: open-drain only ever drives the asserted level
  a_r9_od_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_od && irq_pad_oe) |-> (irq_pad_o == !cfg_actlow));
endmodule

bind irqagg_top irqagg_checker #(.GW(GW), .SYS_LVL(SYS_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .en_w(en_w), .status_w(status_w), .req_w(req_w),
  .irq_act(irq_act), .cfg_actlow(cfg_actlow), .cfg_od(cfg_od),
  .irq_pad_o(irq_pad_o), .irq_pad_oe(irq_pad_oe)
);

// File: tb/sim_irqagg_top.sv
module sim_irqagg_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_ev = '0, rx_ev = '0, sys_ev = '0;
  logic [1:0] mode_i = '0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_pad_o, irq_pad_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irqagg_top u0 (
    .clk(clk), .rst_n(rst_n), .tx_ev(tx_ev), .rx_ev(rx_ev), .sys_ev(sys_ev),
    .mode_i(mode_i), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pad_o(irq_pad_o), .irq_pad_oe(irq_pad_oe)
  );

  // {mode, txen, rxen, sysen, txin, rxin, sysin, cfg, exp_o, exp_oe}
  localparam logic [29:0] VEC [14] = '{
    {2'd0, 4'hF, 4'hF, 4'h0, 4'h3, 4'h3, 4'h0, 2'd0, 1'b0, 1'b1},
    {2'd1, 4'h1, 4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 2'd0, 1'b1, 1'b1},
    {2'd1, 4'h0, 4'h3, 4'h0, 4'h0, 4'h3, 4'h0, 2'd0, 1'b0, 1'b1},
    {2'd2, 4'h3, 4'h2, 4'h0, 4'h3, 4'h2, 4'h0, 2'd0, 1'b1, 1'b1},
    {2'd2, 4'h3, 4'h0, 4'h0, 4'h3, 4'h3, 4'h0, 2'd0, 1'b0, 1'b1},
    {2'd0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h0, 4'h8, 2'd0, 1'b1, 1'b1},
    {2'd0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h8, 2'd0, 1'b0, 1'b1},
    {2'd1, 4'h2, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 2'd1, 1'b0, 1'b1},
    {2'd1, 4'h2, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 2'd1, 1'b1, 1'b1},
    {2'd2, 4'h0, 4'h1, 4'h0, 4'h0, 4'h1, 4'h0, 2'd2, 1'b1, 1'b1},
    {2'd2, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 2'd2, 1'b1, 1'b0},
    {2'd2, 4'h0, 4'h1, 4'h0, 4'h0, 4'h1, 4'h0, 2'd3, 1'b0, 1'b1},
    {2'd1, 4'h0, 4'h1, 4'h0, 4'h0, 4'h1, 4'h0, 2'd3, 1'b0, 1'b0},
    {2'd3, 4'hF, 4'hF, 4'h0, 4'h3, 4'h3, 4'h0, 2'd0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // read-and-clear: returns the value seen in the strobe cycle
  task automatic rd_clr(input logic [2:0] a, input logic [3:0] pulse_sys, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1; sys_ev = sys_ev | pulse_sys; #1; d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; sys_ev = sys_ev & ~pulse_sys;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 pad_o", {7'd0, irq_pad_o}, 8'd0);
    check("R10 pad_oe", {7'd0, irq_pad_oe}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);
    peek(3'd0, d); check("R10 tx_en", d, 8'h00);
    peek(3'd3, d); check("R10 cfg", d, 8'h00);
    peek(3'd6, d); check("R10 sys_st", d, 8'h00);
    peek(3'd7, d); check("R10 unused addr", d, 8'h00);

    // table: R1 R2 R3 R4 R6 R8 R9
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      mode_i = VEC[i][29:28];
      tx_ev = VEC[i][15:12]; rx_ev = VEC[i][11:8]; sys_ev = VEC[i][7:4];
      wr_reg(3'd0, {4'd0, VEC[i][27:24]});
      wr_reg(3'd1, {4'd0, VEC[i][23:20]});
      wr_reg(3'd2, {4'd0, VEC[i][19:16]});
      wr_reg(3'd3, {6'd0, VEC[i][3:2]});
      @(negedge clk);
      check($sformatf("R1/R2/R3/R4/R8/R9 row %0d pad", i),
            {6'd0, irq_pad_o, irq_pad_oe}, {6'd0, VEC[i][1], VEC[i][0]});
      peek(3'd4, d);
      check($sformatf("R6 row %0d tx level status", i), d, {4'd0, VEC[i][15:12]});
    end

    // R5: enables survive mode switches
    tx_ev = '0; rx_ev = '0; sys_ev = '0;
    wr_reg(3'd3, 8'h00);
    wr_reg(3'd0, 8'h05);
    wr_reg(3'd1, 8'h0A);
    @(negedge clk); mode_i = 2'd1;
    @(negedge clk); mode_i = 2'd2;
    @(negedge clk); mode_i = 2'd0;
    @(negedge clk);
    peek(3'd0, d); check("R5 tx_en kept", d, 8'h05);
    peek(3'd1, d); check("R5 rx_en kept", d, 8'h0A);

    // R6: sticky event while disabled is pollable
    wr_reg(3'd2, 8'h00);
    @(negedge clk); sys_ev = 4'b1001;
    @(negedge clk); sys_ev = 4'b1000;
    peek(3'd6, d); check("R6 sticky while disabled", d, 8'h09);
    check("R2 disabled no irq", {7'd0, irq_pad_o}, 8'd0);

    // R7: read of another address clears nothing
    rd_clr(3'd0, 4'b0000, d);
    peek(3'd6, d); check("R7 other addr no clear", d, 8'h09);

    // R7: event in the clearing cycle survives, level bit kept
    rd_clr(3'd6, 4'b0010, d);
    check("R7 read value", d, 8'h09);
    peek(3'd6, d); check("R7 same-cycle event kept", d, 8'h0A);
    rd_clr(3'd6, 4'b0000, d);
    peek(3'd6, d); check("R7 level bit not cleared", d, 8'h08);

    // R1/R7: sticky interrupt raised then dropped after clear
    sys_ev = 4'b0000;
    wr_reg(3'd2, 8'h01);
    @(negedge clk); sys_ev = 4'b0001;
    @(negedge clk); sys_ev = 4'b0000;
    @(negedge clk);
    check("R1 sticky irq asserted", {7'd0, irq_pad_o}, 8'd1);
    rd_clr(3'd6, 4'b0000, d);
    @(negedge clk);
    check("R7 irq drops after clear", {7'd0, irq_pad_o}, 8'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule